// File: doc/BRIEF.md
# Serial Command Frame Receiver with CRC-8 Guard

This block sits on the peripheral side of a four-wire serial bus. While the active-low select line is held low, it shifts in a command frame one bit per falling edge of the serial clock, most significant bit first. When the select line rises, it judges the whole frame. A good frame becomes a single-cycle register-write strobe that carries a 5-bit register address and a 16-bit data word. A bad frame is dropped, and it may raise a one-cycle error pulse.

The bus pins are brought into the system clock domain through synchronizers. Edges are found by oversampling, so the serial clock must run well below the system clock. Each frame carries three guards. The top bit is a slip marker that must be the complement of the bit after it. Two device-address bits must equal the strapped address pins, which lets four receivers share one bus. With checking on, a trailing 8-bit CRC must also match. A control input turns CRC checking off. In that case a 24-bit frame is accepted, and a 32-bit frame is accepted with its last byte disregarded.

Top module: `spi_frame_rx`

## Requirements
- R1: Bits are captured only while sync_n is low, one per falling edge of sclk, MSB first. The same frames decode identically whether sclk idles low (mode 1) or idles high (mode 2).
- R2: The frame bits from the top down are: bit 31 slip marker, bits 30:29 device address, bits 28:24 register address, bits 23:8 data, bits 7:0 CRC. An accepted frame gives one wr_valid pulse with wr_addr = bits 28:24 and wr_data = bits 23:8.
- R3: If bit 31 equals bit 30, the frame writes nothing and slip_err pulses for one cycle, whatever the device address.
- R4: The CRC is the remainder of the 24 header bits times x^8, divided by x^8+x^2+x+1, with zero start and no final inversion. Header 0x8815FA gives 0xA4 and header 0x88AF51 gives 0x31.
- R5: With crc_en high, a 32-bit frame whose CRC byte mismatches writes nothing and pulses crc_err for one cycle.
- R6: A frame with a correct slip marker whose device address differs from dev_addr writes nothing and raises no error.
- R7: With crc_en high, a frame of any length other than 32 clocks is discarded without any pulse.
- R8: With crc_en low, a 24-clock frame is decoded as bits 23:0 of the layout above. A 32-clock frame is decoded with its last 8 bits ignored. Any other length is discarded, and crc_err never pulses.
- R9: After reset all outputs are zero. wr_addr and wr_data change only together with a wr_valid pulse and hold their values otherwise.
- R10: wr_valid, slip_err and crc_err are one-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bus clock |
| sync_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| dev_addr | input | 2 | Strapped device address |
| crc_en | input | 1 | CRC checking enable |
| wr_valid | output | 1 | Register-write strobe |
| wr_addr | output | 5 | Register address of the last write |
| wr_data | output | 16 | Data of the last write |
| slip_err | output | 1 | Slip-marker error pulse |
| crc_err | output | 1 | CRC mismatch pulse |

## Verification
The properties assume three things about the inputs. crc_en is steady around the end of a frame. Successive rises of sync_n are at least two system clocks apart. sclk and sdi change slowly enough that every level is seen by the synchronizers. The stimulus meets these assumptions by holding every serial-clock phase for four system clocks. It also leaves idle time before and after each select pulse and changes crc_en only between frames.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    localparam int FRAME_W = 32;
    localparam int CRC_W   = 8;
    localparam int HEAD_W  = FRAME_W - CRC_W;
    localparam int DEV_W   = 2;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef struct packed {
        logic              slip;
        logic [DEV_W-1:0]  dev;
        logic [REG_W-1:0]  reg_a;
        logic [DATA_W-1:0] data;
    } head_t;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_WRITE = 2'd1,
        V_SLIP  = 2'd2,
        V_CRC   = 2'd3
    } verdict_e;

    // one serial step of the CRC shift register
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sync_n,
    input  logic sdi,
    output logic bit_en,
    output logic bit_val,
    output logic cs_hi,
    output logic frm_start,
    output logic frm_end
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] ck_s;
    logic [STAGES-1:0] cs_s;
    logic [STAGES-1:0] d_s;
    logic              ck_prev;
    logic              cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_s    <= '0;
            cs_s    <= '1;
            d_s     <= '0;
            ck_prev <= 1'b0;
            cs_prev <= 1'b1;
        end else begin
            ck_s    <= {ck_s[STAGES-2:0], sclk};
            cs_s    <= {cs_s[STAGES-2:0], sync_n};
            d_s     <= {d_s[STAGES-2:0], sdi};
            ck_prev <= ck_s[TOP];
            cs_prev <= cs_s[TOP];
        end
    end

    assign cs_hi     = cs_s[TOP];
    assign bit_val   = d_s[TOP];
    assign bit_en    = ck_prev & ~ck_s[TOP] & ~cs_s[TOP];
    assign frm_start = cs_prev & ~cs_s[TOP];
    assign frm_end   = ~cs_prev & cs_s[TOP];

endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
    import spi_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               bit_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] shreg,
    output logic [CNT_W-1:0]   count,
    output logic [CRC_W-1:0]   crc
);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_HEAD = CNT_W'(HEAD_W);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            shreg <= '0;
            count <= '0;
            crc   <= '0;
        end else if (bit_en) begin
            shreg <= {shreg[FRAME_W-2:0], bit_in};
            if (count != CNT_SAT) count <= count + 1'b1;
            if (count < CNT_HEAD) crc <= crc_step(crc, bit_in);
        end
    end

endmodule

// File: rtl/spi_frame_judge.sv
module spi_frame_judge
    import spi_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frm_end,
    input  logic               crc_en,
    input  logic [DEV_W-1:0]   dev_addr,
    input  logic [FRAME_W-1:0] shreg,
    input  logic [CNT_W-1:0]   count,
    input  logic [CRC_W-1:0]   crc,
    output logic               wr_valid,
    output logic [REG_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               slip_err,
    output logic               crc_err
);
    localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(HEAD_W);

    logic     have;
    logic     use_crc;
    head_t    hd;
    verdict_e verdict;

    always_comb begin
        have    = 1'b0;
        use_crc = crc_en;
        hd      = head_t'(shreg[FRAME_W-1:CRC_W]);
        if (crc_en) begin
            have = (count == LEN_FULL);
        end else if (count == LEN_SHORT) begin
            have = 1'b1;
            hd   = head_t'(shreg[HEAD_W-1:0]);
        end else begin
            have = (count == LEN_FULL);
        end

        if (!have)                                verdict = V_NONE;
        else if (hd.slip == hd.dev[DEV_W-1])      verdict = V_SLIP;
        else if (hd.dev != dev_addr)              verdict = V_NONE;
        else if (use_crc && crc != shreg[CRC_W-1:0]) verdict = V_CRC;
        else                                      verdict = V_WRITE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            slip_err <= 1'b0;
            crc_err  <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= frm_end && (verdict == V_WRITE);
            slip_err <= frm_end && (verdict == V_SLIP);
            crc_err  <= frm_end && (verdict == V_CRC);
            if (frm_end && verdict == V_WRITE) begin
                wr_addr <= hd.reg_a;
                wr_data <= hd.data;
            end
        end
    end

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdi,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic              crc_en,
    output logic              wr_valid,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              slip_err,
    output logic              crc_err
);
    logic               bit_en;
    logic               bit_val;
    logic               cs_hi;
    logic               frm_start;
    logic               frm_end;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   count;
    logic [CRC_W-1:0]   crc;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .sync_n    (sync_n),
        .sdi       (sdi),
        .bit_en    (bit_en),
        .bit_val   (bit_val),
        .cs_hi     (cs_hi),
        .frm_start (frm_start),
        .frm_end   (frm_end)
    );

    spi_frame_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (frm_start),
        .bit_en (bit_en),
        .bit_in (bit_val),
        .shreg  (shreg),
        .count  (count),
        .crc    (crc)
    );

    spi_frame_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .frm_end  (frm_end),
        .crc_en   (crc_en),
        .dev_addr (dev_addr),
        .shreg    (shreg),
        .count    (count),
        .crc      (crc),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .slip_err (slip_err),
        .crc_err  (crc_err)
    );

endmodule

// File: rtl/spi_rx_props.sv
module spi_rx_props
    import spi_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              crc_en,
    input logic              cs_hi,
    input logic              wr_valid,
    input logic [REG_W-1:0]  wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              slip_err,
    input logic              crc_err
);
    // R10: the three result pulses never overlap
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, slip_err, crc_err}));

    // R10: a write strobe lasts one cycle
    a_r10_single_wr: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R9: write fields move only with the strobe
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> $stable(wr_addr));
    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> $stable(wr_data));

    // R1: results appear only once the synchronized select has risen
    a_r1_after_release: assert property (@(posedge clk) disable iff (rst)
        (wr_valid || slip_err || crc_err) |-> $past(cs_hi));

    // R8: no CRC error while checking is off
    a_r8_no_crc_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(crc_en) |-> !crc_err);

endmodule

bind spi_frame_rx spi_rx_props u_props (
    .clk      (clk),
    .rst      (rst),
    .crc_en   (crc_en),
    .cs_hi    (cs_hi),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .slip_err (slip_err),
    .crc_err  (crc_err)
);

// File: tb/sim_spi_frame_rx.sv
module sim_spi_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sync_n = 1'b1;
    logic        sdi = 1'b0;
    logic [1:0]  dev_addr = 2'd0;
    logic        crc_en = 1'b1;
    logic        wr_valid;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;
    logic        slip_err;
    logic        crc_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int n_wr = 0, n_slip = 0, n_crc = 0;
    logic [4:0]  exp_a = '0;
    logic [15:0] exp_d = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_rx u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
        .dev_addr(dev_addr), .crc_en(crc_en), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .slip_err(slip_err),
        .crc_err(crc_err)
    );

    always @(posedge clk) begin
        if (wr_valid) n_wr++;
        if (slip_err) n_slip++;
        if (crc_err)  n_crc++;
    end

    // polynomial long division by 0x107
    function automatic logic [7:0] crc_ref(input logic [23:0] h);
        logic [31:0] r;
        r = {h, 8'h00};
        for (int i = 31; i >= 8; i--)
            if (r[i]) r = r ^ (32'h107 << (i - 8));
        return r[7:0];
    endfunction

    function automatic logic [31:0] mk(input bit slip_bad, input logic [1:0] dv,
                                       input logic [4:0] ra, input logic [15:0] dt,
                                       input bit crc_bad);
        logic [23:0] h;
        h = {(slip_bad ? dv[1] : ~dv[1]), dv, ra, dt};
        return {h, crc_ref(h) ^ (crc_bad ? 8'h01 : 8'h00)};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int n, input bit m2);
        sclk = m2;
        wait_clk(HALF_SCK);
        sync_n = 1'b0;
        wait_clk(HALF_SCK);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b1;
            sdi  = v[i];
            wait_clk(HALF_SCK);
            sclk = 1'b0;
            wait_clk(HALF_SCK);
        end
        sclk = m2;
        wait_clk(HALF_SCK);
        sync_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic run(input string req, input logic [63:0] v, input int n,
                       input bit m2, input int ew, input int es, input int ec,
                       input logic [4:0] ea, input logic [15:0] ed);
        int w0, s0, c0;
        w0 = n_wr; s0 = n_slip; c0 = n_crc;
        send(v, n, m2);
        if (ew != 0) begin exp_a = ea; exp_d = ed; end
        total++;
        if ((n_wr - w0) != ew || (n_slip - s0) != es || (n_crc - c0) != ec ||
            wr_addr !== exp_a || wr_data !== exp_d) begin
            bad++;
            $display("FAIL %s: wr=%0d slip=%0d crc=%0d a=%h d=%h, expected wr=%0d slip=%0d crc=%0d a=%h d=%h",
                     req, n_wr - w0, n_slip - s0, n_crc - c0, wr_addr, wr_data,
                     ew, es, ec, exp_a, exp_d);
        end
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R9: reset state
        total++;
        if ({wr_valid, slip_err, crc_err, wr_addr, wr_data} !== '0) begin
            bad++;
            $display("FAIL R9: outputs %b %b %b %h %h, expected all zero",
                     wr_valid, slip_err, crc_err, wr_addr, wr_data);
        end

        // R4: worked examples, mode 1
        run("R4", 64'h8815FAA4, 32, 0, 1, 0, 0, 5'h08, 16'h15FA);
        run("R4", 64'h88AF5131, 32, 0, 1, 0, 0, 5'h08, 16'hAF51);
        // R5: corrupted CRC; R9 last write held
        run("R5", 64'h8815FAA5, 32, 0, 0, 0, 1, 5'h0, 16'h0);
        // R1: mode 2 idle-high clock
        run("R1", 64'h8815FAA4, 32, 1, 1, 0, 0, 5'h08, 16'h15FA);

        // R2: register address sweep, alternating modes, device 2
        dev_addr = 2'd2;
        for (int a = 0; a < 32; a++) begin
            logic [15:0] d;
            d = {a[4:0], ~a[4:0], a[5:0]} ^ 16'h5A3C;
            run("R2", {32'h0, mk(0, 2'd2, a[4:0], d, 0)}, 32, a[0], 1, 0, 0, a[4:0], d);
        end

        // R3 / R6: pins x frame address x slip marker
        for (int p = 0; p < 4; p++) begin
            dev_addr = p[1:0];
            for (int f = 0; f < 4; f++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] d;
                    d = 16'h1000 + 16'(p * 8 + f * 2 + s);
                    if (s == 1)
                        run("R3", {32'h0, mk(1, f[1:0], 5'h11, d, 0)}, 32, 0, 0, 1, 0, 0, 0);
                    else if (f == p)
                        run("R6", {32'h0, mk(0, f[1:0], 5'h11, d, 0)}, 32, 1, 1, 0, 0, 5'h11, d);
                    else
                        run("R6", {32'h0, mk(0, f[1:0], 5'h11, d, 0)}, 32, 0, 0, 0, 0, 0, 0);
                end
            end
        end

        // R7: wrong lengths with checking on
        dev_addr = 2'd1;
        for (int n = 20; n <= 35; n++) begin
            logic [31:0] fr;
            logic [63:0] v;
            if (n == 32) continue;
            fr = mk(0, 2'd1, 5'h03, 16'hBEEF, 0);
            v = (n < 32) ? 64'(fr >> (32 - n)) : (64'(fr) << (n - 32));
            run("R7", v, n, n[0], 0, 0, 0, 0, 0);
        end
        // R7: bad slip on a short frame is still silent
        run("R7", {32'h0, mk(1, 2'd1, 5'h03, 16'hBEEF, 0)} >> 8, 24, 0, 0, 0, 0, 0, 0);

        // R8: checking off
        crc_en = 1'b0;
        wait_clk(4);
        run("R8", {32'h0, mk(0, 2'd1, 5'h1E, 16'h0C40, 0)} >> 8, 24, 0, 1, 0, 0, 5'h1E, 16'h0C40);
        run("R8", {32'h0, mk(0, 2'd1, 5'h07, 16'h1DAC, 1)}, 32, 1, 1, 0, 0, 5'h07, 16'h1DAC);
        run("R8", {32'h0, mk(0, 2'd1, 5'h05, 16'h2222, 0)} >> 4, 28, 0, 0, 0, 0, 0, 0);
        run("R8", {32'h0, mk(1, 2'd1, 5'h05, 16'h3333, 0)} >> 8, 24, 0, 0, 1, 0, 0, 0);
        run("R8", {32'h0, mk(0, 2'd3, 5'h05, 16'h4444, 0)} >> 8, 24, 1, 0, 0, 0, 0, 0);
        crc_en = 1'b1;
        wait_clk(4);
        run("R5", {32'h0, mk(0, 2'd1, 5'h07, 16'h1DAC, 1)}, 32, 0, 0, 0, 1, 0, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1: watchdog expired, run incomplete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule